// File: doc/BRIEF.md
# Line-Frequency Time-of-Day Counter Chain

This block keeps the time of day from a stream of single-cycle pulses, one per cycle of the AC mains, already synchronised to the system clock. A prescaler divides the stream by 50 or by 60 and produces a once-per-second strobe and a ten-per-second strobe. Three BCD counters for seconds, minutes and hours follow the prescaler. The hours counter wraps either as a 24-hour count or as a 12-hour count. All stages run on the one system clock. Each stage passes a carry enable that lasts one cycle to the next stage.

Time is set by steering the raw line pulses to a different point in the chain, so the setting rate follows the mains rate. A small routing state machine has four states. RT_RUN feeds the prescaler. RT_HOLD feeds nothing. RT_SLOW feeds each pulse into the seconds counter. RT_FAST feeds each pulse into the minutes counter. On every clock edge the next state is chosen from the set inputs, in priority order: hold, then fast, then slow, otherwise run. Any state can move to any other state in one edge.

Top module: `mains_tod_chain`

## Requirements
- R1: With `sel_60hz` low, `tick_1hz` pulses once for every 50 line pulses routed to the prescaler. With `sel_60hz` high, it pulses once for every 60. Each pulse lands on the line pulse that completes the count after reset.
- R2: `tick_10hz` pulses on every 5th routed line pulse (every 6th when `sel_60hz` is high). `tick_1hz` only ever appears together with every 10th `tick_10hz`. Both strobes are high in the same cycle as the line pulse that causes them.
- R3: While the routing state is RT_HOLD, no counter changes and no strobe fires.
- R4: Seconds and minutes count 00 to 59 in BCD (units 0–9, tens 0–5). Each wraps to 00 and carries one step into the next stage in the same clock.
- R5: In RT_SLOW, every line pulse advances seconds by one. The prescaler receives nothing, so neither strobe fires.
- R6: In RT_FAST, every line pulse advances minutes by one. Seconds stay unchanged.
- R7: With `sel_12h` low, hours count 00 to 23 in BCD and wrap from 23 to 00.
- R8: With `sel_12h` high, hours roll from 12 to 01, and an hour of 00 advances to 01.
- R9: Asserting `rst_n` low clears seconds, minutes, hours and the prescaler to zero, whatever the other inputs are.
- R10: If several set inputs are high together, hold wins over fast and fast wins over slow.
- R11: A line pulse is routed by the set inputs sampled on the previous clock edge. A pulse that arrives in the same cycle a set input first rises still follows the earlier route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low clear of the whole chain |
| line_pulse | input | 1 | One-cycle pulse per mains cycle |
| sel_60hz | input | 1 | 1: divide by 60, 0: divide by 50 |
| sel_12h | input | 1 | 1: 12-hour wrap, 0: 24-hour wrap |
| hold | input | 1 | Block all line pulses |
| slow_set | input | 1 | Route line pulses into seconds |
| fast_set | input | 1 | Route line pulses into minutes |
| sec_units | output | 4 | Seconds units, BCD |
| sec_tens | output | 4 | Seconds tens, BCD |
| min_units | output | 4 | Minutes units, BCD |
| min_tens | output | 4 | Minutes tens, BCD |
| hr_units | output | 4 | Hours units, BCD |
| hr_tens | output | 4 | Hours tens, BCD |
| tick_1hz | output | 1 | Once-per-second strobe |
| tick_10hz | output | 1 | Ten-per-second strobe |

## Verification
A bad prescaler count shows up as a displaced `tick_1hz` on the first second after reset. It is therefore caught within 50 or 60 line pulses. A wrong routing state shows up on the first pulse after a set input changes: the wrong digit moves, or a strobe fires that should not. A bad wrap in any digit stays hidden until that digit reaches its limit. For that reason the hour boundaries of 23, 12 and 00 are driven to directly with fast setting, instead of being waited for.

// File: rtl/tod_pkg.sv
package tod_pkg;
    typedef enum logic [1:0] {
        RT_RUN  = 2'd0,
        RT_HOLD = 2'd1,
        RT_SLOW = 2'd2,
        RT_FAST = 2'd3
    } route_e;
endpackage

// File: rtl/tod_router.sv
module tod_router
    import tod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_pulse,
    input  logic hold,
    input  logic slow_set,
    input  logic fast_set,
    output logic pre_en,
    output logic sec_inj,
    output logic min_inj
);
    route_e st, st_nx;

    always_comb begin
        if (hold)          st_nx = RT_HOLD;
        else if (fast_set) st_nx = RT_FAST;
        else if (slow_set) st_nx = RT_SLOW;
        else               st_nx = RT_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RT_RUN;
        else        st <= st_nx;
    end

    always_comb begin
        pre_en  = 1'b0;
        sec_inj = 1'b0;
        min_inj = 1'b0;
        unique case (st)
            RT_RUN:  pre_en  = line_pulse;
            RT_HOLD: ;
            RT_SLOW: sec_inj = line_pulse;
            RT_FAST: min_inj = line_pulse;
        endcase
    end

    AST_HOLD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (st == RT_HOLD));                          // R10
    AST_FAST_OVER_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && fast_set) |=> (st == RT_FAST));           // R10
endmodule

// File: rtl/tod_prescale.sv
module tod_prescale #(
    parameter int LINE_LO   = 50,
    parameter int LINE_HI   = 60,
    parameter int TAP_RATIO = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sel_hi,
    output logic tick_tap,
    output logic tick_sec
);
    localparam int SUB_LO = LINE_LO / TAP_RATIO - 1;
    localparam int SUB_HI = LINE_HI / TAP_RATIO - 1;
    localparam int SW     = $clog2(SUB_HI + 1);
    localparam int DW     = $clog2(TAP_RATIO);

    logic [SW-1:0] sub_q, sub_max;
    logic [DW-1:0] dec_q;
    logic          sub_wrap, dec_wrap;

    assign sub_max  = sel_hi ? SW'(SUB_HI) : SW'(SUB_LO);
    assign sub_wrap = (sub_q >= sub_max);
    assign dec_wrap = (dec_q == DW'(TAP_RATIO - 1));
    assign tick_tap = en && sub_wrap;
    assign tick_sec = tick_tap && dec_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
            dec_q <= '0;
        end else if (en) begin
            sub_q <= sub_wrap ? '0 : sub_q + 1'b1;
            if (sub_wrap) dec_q <= dec_wrap ? '0 : dec_q + 1'b1;
        end
    end

    AST_TAP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_tap |=> !tick_tap);                            // R2
    AST_SEC_ON_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sec |=> (dec_q == '0));                        // R2
endmodule

// File: rtl/tod_bcd_mod60.sv
module tod_bcd_mod60 #(
    parameter int UNIT_MAX = 9,
    parameter int TENS_MAX = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    output logic [3:0] units,
    output logic [3:0] tens,
    output logic       carry
);
    logic unit_top, tens_top;

    assign unit_top = (units == 4'(UNIT_MAX));
    assign tens_top = (tens == 4'(TENS_MAX));
    assign carry    = en && unit_top && tens_top;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            units <= '0;
            tens  <= '0;
        end else if (en) begin
            if (unit_top) begin
                units <= '0;
                tens  <= tens_top ? '0 : tens + 1'b1;
            end else begin
                units <= units + 1'b1;
            end
        end
    end

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (units <= 4'(UNIT_MAX)) && (tens <= 4'(TENS_MAX)));  // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (units == '0 && tens == '0));             // R4
endmodule

// File: rtl/tod_hours.sv
module tod_hours (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       mode12,
    output logic [3:0] units,
    output logic [3:0] tens
);
    logic [4:0] val;

    assign val = 5'(tens) * 5'd10 + 5'(units);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            units <= '0;
            tens  <= '0;
        end else if (en) begin
            if (mode12 && val >= 5'd12) begin
                units <= 4'd1;
                tens  <= 4'd0;
            end else if (!mode12 && val >= 5'd23) begin
                units <= '0;
                tens  <= '0;
            end else if (units == 4'd9) begin
                units <= '0;
                tens  <= tens + 1'b1;
            end else begin
                units <= units + 1'b1;
            end
        end
    end

    AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tens <= 4'd2) && (units <= 4'd9) && !(tens == 4'd2 && units > 4'd3)); // R7
    AST_HR12_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode12 && tens == 4'd1 && units == 4'd2) |=> (tens == 4'd0 && units == 4'd1)); // R8
endmodule

// File: rtl/mains_tod_chain.sv
module mains_tod_chain #(
    parameter int LINE_LO   = 50,
    parameter int LINE_HI   = 60,
    parameter int TAP_RATIO = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_pulse,
    input  logic       sel_60hz,
    input  logic       sel_12h,
    input  logic       hold,
    input  logic       slow_set,
    input  logic       fast_set,
    output logic [3:0] sec_units,
    output logic [3:0] sec_tens,
    output logic [3:0] min_units,
    output logic [3:0] min_tens,
    output logic [3:0] hr_units,
    output logic [3:0] hr_tens,
    output logic       tick_1hz,
    output logic       tick_10hz
);
    logic pre_en, sec_inj, min_inj;
    logic sec_carry, min_carry;

    tod_router u_route (
        .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse),
        .hold(hold), .slow_set(slow_set), .fast_set(fast_set),
        .pre_en(pre_en), .sec_inj(sec_inj), .min_inj(min_inj)
    );

    tod_prescale #(.LINE_LO(LINE_LO), .LINE_HI(LINE_HI), .TAP_RATIO(TAP_RATIO)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(pre_en), .sel_hi(sel_60hz),
        .tick_tap(tick_10hz), .tick_sec(tick_1hz)
    );

    tod_bcd_mod60 u_sec (
        .clk(clk), .rst_n(rst_n), .en(tick_1hz || sec_inj),
        .units(sec_units), .tens(sec_tens), .carry(sec_carry)
    );

    tod_bcd_mod60 u_min (
        .clk(clk), .rst_n(rst_n), .en(sec_carry || min_inj),
        .units(min_units), .tens(min_tens), .carry(min_carry)
    );

    tod_hours u_hr (
        .clk(clk), .rst_n(rst_n), .en(min_carry), .mode12(sel_12h),
        .units(hr_units), .tens(hr_tens)
    );

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |=> $stable({sec_units, sec_tens, min_units, min_tens, hr_units, hr_tens})); // R3
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> !(tick_1hz || tick_10hz)); // R3
endmodule

// File: tb/sim_mains_tod_chain.sv
module sim_mains_tod_chain;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_pulse = 1'b0, sel_60hz = 1'b0, sel_12h = 1'b0;
    logic hold = 1'b0, slow_set = 1'b0, fast_set = 1'b0;
    logic [3:0] sec_units, sec_tens, min_units, min_tens, hr_units, hr_tens;
    logic tick_1hz, tick_10hz;

    always #2 clk = ~clk;

    mains_tod_chain u0 (
        .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse),
        .sel_60hz(sel_60hz), .sel_12h(sel_12h),
        .hold(hold), .slow_set(slow_set), .fast_set(fast_set),
        .sec_units(sec_units), .sec_tens(sec_tens),
        .min_units(min_units), .min_tens(min_tens),
        .hr_units(hr_units), .hr_tens(hr_tens),
        .tick_1hz(tick_1hz), .tick_10hz(tick_10hz)
    );

    typedef struct {int h; int m; int s; string req;} exp_t;
    exp_t sb_q[$];
    int n_vec = 0, n_bad = 0;
    int n10, n1, last1;

    task automatic check_int(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_exp(int h, int m, int s, string req);
        exp_t e;
        e.h = h; e.m = m; e.s = s; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops expected times and compares against the BCD outputs
    initial forever begin
        @(negedge clk);
        while (sb_q.size() > 0) begin
            exp_t e;
            int ah, am, as_;
            e = sb_q.pop_front();
            ah = hr_tens * 10 + hr_units;
            am = min_tens * 10 + min_units;
            as_ = sec_tens * 10 + sec_units;
            n_vec++;
            if (ah != e.h || am != e.m || as_ != e.s) begin
                n_bad++;
                $display("FAIL %s: actual %0d:%0d:%0d expected %0d:%0d:%0d",
                         e.req, ah, am, as_, e.h, e.m, e.s);
            end
        end
    end

    task automatic clear_counts;
        n10 = 0; n1 = 0; last1 = 0;
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_pulse = 1'b1;
            #1;
            if (tick_10hz) n10++;
            if (tick_1hz) begin n1++; last1 = i + 1; end
            @(negedge clk);
            line_pulse = 1'b0;
        end
    endtask

    task automatic setctl(logic h, logic s, logic f);
        @(negedge clk);
        hold = h; slow_set = s; fast_set = f;
        @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset;
        push_exp(0, 0, 0, "R9 reset state");

        // R1 R2: default divide by 50
        clear_counts; pulses(50);
        check_int("R1 ticks per 50", n1, 1);
        check_int("R1 tick on pulse 50", last1, 50);
        check_int("R2 tap strobes per 50", n10, 10);
        push_exp(0, 0, 1, "R1 one second");

        // R1 R2: divide by 60
        @(negedge clk); sel_60hz = 1'b1; @(negedge clk);
        clear_counts; pulses(60);
        check_int("R1 ticks per 60", n1, 1);
        check_int("R1 tick on pulse 60", last1, 60);
        check_int("R2 tap strobes per 60", n10, 10);
        push_exp(0, 0, 2, "R1 second at 60");

        // R5 slow set, R4 seconds wrap into minutes
        setctl(1'b0, 1'b1, 1'b0);
        clear_counts; pulses(58);
        check_int("R5 no 1hz in slow", n1, 0);
        check_int("R5 no 10hz in slow", n10, 0);
        push_exp(0, 1, 0, "R4 R5 seconds wrap");

        // R6 fast set, R4 minute wrap into hours
        setctl(1'b0, 1'b0, 1'b1);
        pulses(59);
        push_exp(1, 0, 0, "R6 R4 minute wrap");

        // R3 hold
        setctl(1'b1, 1'b0, 1'b0);
        clear_counts; pulses(20);
        check_int("R3 no strobe in hold", n1 + n10, 0);
        push_exp(1, 0, 0, "R3 hold frozen");

        // R10 priorities
        setctl(1'b1, 1'b0, 1'b1);
        pulses(5);
        push_exp(1, 0, 0, "R10 hold over fast");
        setctl(1'b0, 1'b1, 1'b1);
        pulses(3);
        push_exp(1, 3, 0, "R10 fast over slow");

        // R7 24-hour wrap
        setctl(1'b0, 1'b0, 1'b1);
        pulses(1376);
        push_exp(23, 59, 0, "R7 reach 23:59");
        pulses(1);
        push_exp(0, 0, 0, "R7 23 to 00");

        // R8 12-hour format
        setctl(1'b0, 1'b0, 1'b0);
        sel_12h = 1'b1;
        do_reset;
        push_exp(0, 0, 0, "R9 reset in 12h");
        setctl(1'b0, 1'b0, 1'b1);
        pulses(60);
        push_exp(1, 0, 0, "R8 00 to 01");
        pulses(660);
        push_exp(12, 0, 0, "R8 reach 12");
        pulses(60);
        push_exp(1, 0, 0, "R8 12 to 01");

        // R9 reset clears prescaler too
        setctl(1'b0, 1'b0, 1'b0);
        sel_12h = 1'b0; sel_60hz = 1'b0;
        pulses(30);
        do_reset;
        push_exp(0, 0, 0, "R9 reset mid-run");
        clear_counts; pulses(49);
        check_int("R9 prescaler cleared", n1, 0);

        // R11 pulse in the cycle hold rises still goes to prescaler
        clear_counts;
        @(negedge clk);
        hold = 1'b1; line_pulse = 1'b1;
        #1;
        if (tick_1hz) n1++;
        @(negedge clk);
        line_pulse = 1'b0;
        check_int("R11 old route used", n1, 1);
        push_exp(0, 0, 1, "R11 second counted");
        pulses(10);
        push_exp(0, 0, 1, "R3 hold after latency");

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule